// File: doc/BRIEF.md
# Overlap-safe block transfer sequencer

This block carries out a screen-to-screen rectangle copy. A command arrives as four 32-bit words on a valid/ready port. The sequencer then walks every pixel of the rectangle. For each pixel it issues one read of the source pixel and then one write of that value to the matching destination pixel. Both accesses go through a simple request/acknowledge memory port. Pixel addresses are linear: row times a fixed line stride, plus column.

A two-bit scan-direction code in the first word chooses the corner the walk starts from and the sign of the X and Y steps. The issuer picks the code from how the source and destination origins relate. That choice keeps an overlapping copy from reading pixels it has already overwritten. The host may poll `busy_o` to learn when the copy has finished.

Top module: `blit_seq`

## Requirements
- R1: A command is four words accepted in this order: a control word, the source origin, the destination origin and the size. Origins carry Y in bits 31:16 and X in bits 15:0. The size word carries the height in bits 31:16 and the width in bits 15:0.
- R2: The scan direction is bits 17:16 of the control word. With bit 16 set, X runs from the right edge (width-1) down to 0. With bit 17 set, Y runs from the bottom row (height-1) up to 0. All other control bits have no effect.
- R3: Pixels are visited row by row, with X as the inner loop and Y as the outer loop. Every pixel of the rectangle is visited exactly once.
- R4: The address of pixel (x, y) is y*STRIDE + x. The source and destination addresses of a step use the same offset from their own origin.
- R5: Each step raises `rd_req_o` and holds it, with a stable address, until `rd_ack_i`. It captures `rd_data_i` on that cycle. It then raises `wr_req_o` and holds it, with stable address and data, until `wr_ack_i`. The data written is the value read. The two requests are never high together.
- R6: At most one read is outstanding. After a read is acknowledged, no new read is issued until the matching write has been acknowledged.
- R7: A command with zero width or zero height makes no memory access. `busy_o` is low in the cycle after its last word is accepted.
- R8: `busy_o` goes high in the cycle after the first command word is accepted. It stays high until the cycle after the last write is acknowledged. `cmd_ready_o` is low exactly while the pixel walk is in progress.
- R9: When the direction code is chosen from the origins, the destination ends up holding the original source contents even if the two rectangles overlap. Code 0 is used when source X >= destination X and source Y >= destination Y. Code 2 is used when only source X >= destination X. Code 1 is used when only source Y >= destination Y. Code 3 is used otherwise.
- R10: After reset, `busy_o`, `rd_req_o` and `wr_req_o` are low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Command word accepted when high with valid |
| busy_o | output | 1 | Command in progress |
| rd_req_o | output | 1 | Source read request |
| rd_addr_o | output | ADDR_W | Source pixel address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Destination write request |
| wr_addr_o | output | ADDR_W | Destination pixel address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
Acceptance of a command word registers at a clock edge, so `busy_o` is due one cycle later. The reference model updates its busy expectation just after that edge and compares at the following falling edge. A read acknowledge moves the block to its write phase at the next edge, and a write acknowledge starts the next read or ends the command at the next edge. The bench's memory responder therefore compares each request's address and data at the falling edge on which it grants the acknowledge. It retires the expected busy and ready state one falling edge later. Response latency is varied from zero to two cycles, and the final destination contents are compared against a snapshot of the source.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned COORD_W = WORD_W / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} blit_st_e;

  typedef struct packed {
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } blit_xy_t;
endpackage

// File: rtl/blit_cmd_rx.sv
module blit_cmd_rx
  import blit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              collecting_o,
  output logic              pkt_done_o,
  output logic [1:0]        dir_o,
  output blit_xy_t          src_o,
  output blit_xy_t          dst_o
);
  logic [1:0] cnt_q;

  assign collecting_o = (cnt_q != 2'd0);
  assign pkt_done_o   = take_i && (cnt_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_o <= '0;
      src_o <= '0;
      dst_o <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 2'd1;
      case (cnt_q)
        2'd0:    dir_o <= word_i[17:16];
        2'd1:    src_o <= word_i;
        2'd2:    dst_o <= word_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [1:0]         dir_i,
  input  blit_xy_t           size_i,
  output logic               empty_o,
  output logic [COORD_W-1:0] x_off_o,
  output logic [COORD_W-1:0] y_off_o,
  output logic               last_o
);
  logic [COORD_W-1:0] w_q, h_q, xc_q, yc_q;
  logic [1:0]         dir_q;
  logic               x_end;

  assign empty_o = (size_i.x == '0) || (size_i.y == '0);
  assign x_end   = (xc_q == w_q - 1'b1);
  assign last_o  = x_end && (yc_q == h_q - 1'b1);
  // descending axes count from the far edge
  assign x_off_o = dir_q[0] ? (w_q - 1'b1 - xc_q) : xc_q;
  assign y_off_o = dir_q[1] ? (h_q - 1'b1 - yc_q) : yc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      h_q   <= '0;
      xc_q  <= '0;
      yc_q  <= '0;
      dir_q <= '0;
    end else if (load_i) begin
      w_q   <= size_i.x;
      h_q   <= size_i.y;
      dir_q <= dir_i;
      xc_q  <= '0;
      yc_q  <= '0;
    end else if (step_i) begin
      if (x_end) begin
        xc_q <= '0;
        yc_q <= yc_q + 1'b1;
      end else begin
        xc_q <= xc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STRIDE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_data_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i
);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);

  blit_st_e           st_q;
  logic               take, collecting, pkt_done, empty, last;
  logic [1:0]         dir;
  blit_xy_t           src, dst;
  logic [COORD_W-1:0] x_off, y_off;
  logic [DATA_W-1:0]  data_q;

  function automatic logic [ADDR_W-1:0] pix_addr(input logic [COORD_W-1:0] y,
                                                  input logic [COORD_W-1:0] x);
    return ADDR_W'(y) * STRIDE_A + ADDR_W'(x);
  endfunction

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign take        = cmd_valid_i && cmd_ready_o;
  assign busy_o      = collecting || (st_q != ST_IDLE);

  blit_cmd_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .word_i       (cmd_data_i),
    .collecting_o (collecting),
    .pkt_done_o   (pkt_done),
    .dir_o        (dir),
    .src_o        (src),
    .dst_o        (dst)
  );

  blit_walker u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pkt_done),
    .step_i  ((st_q == ST_WR) && wr_ack_i),
    .dir_i   (dir),
    .size_i  (blit_xy_t'(cmd_data_i)),
    .empty_o (empty),
    .x_off_o (x_off),
    .y_off_o (y_off),
    .last_o  (last)
  );

  assign rd_req_o  = (st_q == ST_RD);
  assign wr_req_o  = (st_q == ST_WR);
  assign rd_addr_o = pix_addr(src.y + y_off, src.x + x_off);
  assign wr_addr_o = pix_addr(dst.y + y_off, dst.x + x_off);
  assign wr_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (pkt_done && !empty) st_q <= ST_RD;
        ST_RD: if (rd_ack_i) begin
          data_q <= rd_data_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (wr_ack_i) st_q <= last ? ST_IDLE : ST_RD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  // R5
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> wr_req_o && !rd_req_o);

  // R8
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || wr_req_o) |-> busy_o && !cmd_ready_o);

  // R8
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cmd_ready_o);
endmodule

bind blit_seq blit_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .busy_o      (busy_o),
  .rd_req_o    (rd_req_o),
  .rd_ack_i    (rd_ack_i),
  .rd_addr_o   (rd_addr_o),
  .wr_req_o    (wr_req_o),
  .wr_ack_i    (wr_ack_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/blit_seq_test.sv
`timescale 1ns/1ps
module blit_seq_test;
  localparam int unsigned STRIDE = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic        cmd_ready_o, busy_o;
  logic        rd_req_o, rd_ack_i, wr_req_o, wr_ack_i;
  logic [31:0] rd_addr_o, wr_addr_o, rd_data_i, wr_data_o;

  always #2.5 clk = ~clk;

  blit_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_data_i(cmd_data_i), .cmd_ready_o(cmd_ready_o),
    .busy_o(busy_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference state
  logic [31:0] mem [int unsigned];
  int unsigned q_rd[$];
  int unsigned q_wr[$];
  logic [31:0] q_dat[$];
  bit mbusy = 0;
  bit mrun  = 0;
  int rem   = 0;
  int lat   = 0;
  int lat_cnt = 0;

  function automatic logic [31:0] memv(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return a * 32'h9E37 + 32'd5;
  endfunction

  function automatic int unsigned pa(input int y, input int x);
    return int'(y) * STRIDE + int'(x);
  endfunction

  // memory responder and per-clock comparison
  always @(negedge clk) begin
    if (!rst_ni) begin
      rd_ack_i = 1'b0; wr_ack_i = 1'b0; rd_data_i = '0; lat_cnt = 0;
    end else begin
      if (rd_ack_i) rd_ack_i = 1'b0;
      if (wr_ack_i) begin
        wr_ack_i = 1'b0;
        rem--;
        if (rem == 0) begin mrun = 0; mbusy = 0; end
      end
      chk(busy_o == mbusy, "R8 busy", busy_o, mbusy);
      chk(cmd_ready_o == !mrun, "R8 ready", cmd_ready_o, !mrun);
      if (rd_req_o) begin
        if (lat_cnt < lat) lat_cnt++;
        else begin
          lat_cnt = 0;
          chk(q_rd.size() > 0, "R6/R7 unexpected read", 1, 0);
          if (q_rd.size() > 0) begin
            chk(rd_addr_o == q_rd[0], "R3/R4 read addr", rd_addr_o, q_rd[0]);
            void'(q_rd.pop_front());
          end
          rd_data_i = memv(rd_addr_o);
          q_dat.push_back(rd_data_i);
          rd_ack_i = 1'b1;
        end
      end else if (wr_req_o) begin
        if (lat_cnt < lat) lat_cnt++;
        else begin
          lat_cnt = 0;
          chk(q_wr.size() > 0 && q_dat.size() > 0, "R5/R7 unexpected write", 1, 0);
          if (q_wr.size() > 0 && q_dat.size() > 0) begin
            chk(wr_addr_o == q_wr[0], "R3/R4 write addr", wr_addr_o, q_wr[0]);
            chk(wr_data_o == q_dat[0], "R5 write data", wr_data_o, q_dat[0]);
            void'(q_wr.pop_front());
            void'(q_dat.pop_front());
          end
          mem[wr_addr_o] = wr_data_o;
          wr_ack_i = 1'b1;
        end
      end
    end
  end

  task automatic send(input logic [31:0] w, input bit last_word, input bit nonempty);
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_data_i  = w;
    @(posedge clk);
    if (!last_word) mbusy = 1;
    else begin mbusy = nonempty; mrun = nonempty; end
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic run_copy(input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input bit junk, input int gap,
                          input string tag);
    int dir;
    logic [31:0] ctrl;
    logic [31:0] snap[];
    bit ok;
    if (sx >= dx && sy >= dy) dir = 0;
    else if (sx >= dx) dir = 2;
    else if (sy >= dy) dir = 1;
    else dir = 3;
    ctrl = junk ? (32'hF0FC_5A5A | (dir << 16)) : (32'h0D44_0000 | (dir << 16));
    snap = new[w * h];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        snap[j * w + i] = memv(pa(sy + j, sx + i));
    for (int j = 0; j < h; j++) begin
      int y = dir[1] ? h - 1 - j : j;
      for (int i = 0; i < w; i++) begin
        int x = dir[0] ? w - 1 - i : i;
        q_rd.push_back(pa(sy + y, sx + x));
        q_wr.push_back(pa(dy + y, dx + x));
      end
    end
    rem = w * h;
    send(ctrl, 0, 0);
    repeat (gap) @(negedge clk);
    send({16'(sy), 16'(sx)}, 0, 0);
    send({16'(dy), 16'(dx)}, 0, 0);
    repeat (gap) @(negedge clk);
    send({16'(h), 16'(w)}, 1, rem != 0);
    while (mbusy) @(negedge clk);
    repeat (3) @(negedge clk);
    ok = 1;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (memv(pa(dy + j, dx + i)) != snap[j * w + i]) ok = 0;
    chk(ok, tag, ok, 1);
    chk(q_rd.size() == 0 && q_wr.size() == 0, "R3 all pixels visited",
        q_rd.size() + q_wr.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o == 0, "R10 busy", busy_o, 0);
    chk(cmd_ready_o == 1, "R10 ready", cmd_ready_o, 1);
    chk(!rd_req_o && !wr_req_o, "R10 requests", rd_req_o | wr_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    lat = 0; run_copy(2, 3, 20, 10, 4, 3, 0, 0, "R1 disjoint copy");
    lat = 1; run_copy(5, 5, 7, 6, 5, 4, 0, 1, "R9 overlap code 3");
    lat = 2; run_copy(9, 4, 7, 6, 4, 5, 0, 0, "R9 overlap code 2");
    lat = 0; run_copy(3, 9, 5, 7, 5, 4, 0, 2, "R9 overlap code 1");
    lat = 1; run_copy(8, 8, 6, 7, 6, 3, 0, 0, "R9 overlap code 0");
    lat = 0; run_copy(4, 4, 6, 6, 4, 4, 1, 0, "R2 other control bits ignored");
    lat = 2; run_copy(30, 2, 31, 2, 1, 6, 0, 0, "R2 single column");
    lat = 0; run_copy(10, 20, 10, 21, 7, 1, 0, 1, "R2 single row");
    lat = 0; run_copy(1, 1, 40, 40, 0, 5, 0, 0, "R7 zero width");
    lat = 0; run_copy(1, 1, 40, 40, 5, 0, 1, 1, "R7 zero height");
    chk(busy_o == 0 && cmd_ready_o == 1, "R7 idle after empty", busy_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule